// File: doc/BRIEF.md
# Parallel ATA PIO Register Access Sequencer

This block runs single PIO register reads and writes on a parallel ATA or CompactFlash bus. A host hands it one access at a time: a register address, a direction flag and, for writes, a data word. The block frames the access with chip select, then sequences the address setup, the read or write strobe, the address hold, a data-hold or bus-release tail, and the recovery before the next access. For a read it returns the captured word with a one-cycle done pulse.

Each phase length is a clock count. The counts are worked out at elaboration from the clock period parameter and a per-mode nanosecond table that covers PIO modes 0 to 6. A request picks the timing of the mode that is active when it is accepted. The host changes the mode through a separate set command. The mode only moves towards slower timing once a first mode has been chosen. In the slower modes the device can stretch the strobe by pulling IORDY low. A status read that returns the idle-bus pattern 0xF9 in its low byte has that byte turned into 0x7F.

Top module: `pata_pio_engine`

## Requirements
- R1: After reset, req_ready is 1, cs_n, dior_n and diow_n are 1, dd_oe and done are 0. Until the first mode set command, accesses use mode 0 timing.
- R2: A time t in ps becomes clocks as follows, with clock period P. If t <= 0 the result is 0. Otherwise let e = min(floor(2t/100), floor(P/4)); the result is floor((t + P - 1 - e) / P). The effect is to round up, except that a time at most e beyond a clock boundary rounds down.
- R3: The base counts are: setup = max(1, clk(t_su)); strobe = max(2, clk(t_st)); hold = max(1, clk(t_ho)); tail = clk(t_x - hold*P); recovery = clk(t_rc). Here t_x is the write data hold for writes and the read release time for reads. The values in ns for modes 0..6 are: t_su 70,50,30,30,25,15,10; t_st 290,290,290,80,70,65,55; t_ho 20,15,10,10,10,10,10; write hold 30,20,15,10,10,10,10; read release 30,30,30,30,30,20,20; t_rc 0,0,0,70,25,25,20.
- R4: The minimum cycle is clk(t_cyc), with t_cyc 600,383,240,180,120,100,80 ns for modes 0..6. While the five counts add up to less than this, the phases are visited in the order setup, strobe, hold, tail, recovery, wrapping around, and each nonzero phase visited gains one clock.
- R5: cs_n is low for exactly the setup, strobe and hold cycles. The strobe (dior_n for reads, diow_n for writes) is low only in the strobe cycles. da holds the request address throughout the access. For a write, dd_oe is high with dd_out equal to the write data from the first setup cycle through the last tail cycle.
- R6: Read data is sampled from dd_in at the clock edge one cycle before dior_n rises. done is high for exactly one cycle, the first idle cycle after the access, and rdata then holds the read result.
- R7: A read at address 7 or 14 whose low byte is 0xF9 returns 0x7F in the low byte, with the upper byte unchanged. Other addresses and other values return dd_in unchanged.
- R8: In modes 0 to 4, while iordy is low the strobe holds in its second-to-last cycle, so the strobe lasts the nominal count plus the number of stalled cycles. In modes 5 and 6, iordy has no effect.
- R9: A mode set command with mode_sel 7 is treated as mode 6.
- R10: The first mode set command after reset always takes effect. After that, a command takes effect only when its (clamped) mode number is lower than the active one; other commands are ignored.
- R11: req_ready is 1 only while no access is in progress, that is, once recovery has ended. A request is accepted on a clock edge where req_valid and req_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_set | input | 1 | Mode set command strobe |
| mode_sel | input | 3 | Requested PIO mode |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer idle, request can be accepted |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-cycle access completion pulse |
| rdata | output | DW | Read result |
| cs_n | output | 1 | Chip select, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| da | output | AW | Device register address |
| dd_out | output | DW | Data driven to the device |
| dd_oe | output | 1 | Data output enable |
| dd_in | input | DW | Data from the device |
| iordy | input | 1 | Device ready, low stretches the strobe |

## Verification
The bench builds two copies. One has CLK_PS = 10000, which matches its 100 MHz clock. That copy covers all seven modes for both directions, and in modes 0 and 1 it needs the round-robin stretch to reach the minimum cycle. The second copy has CLK_PS = 6000. In mode 6 that period makes the 55 ns strobe round down by the 2% tolerance. In mode 0 the quarter-clock cap keeps the 290 ns strobe from rounding down, and the cycle stretch spreads 34 extra clocks over four phases.

// File: rtl/pata_pio_engine.sv
module pata_pio_engine #(
  parameter int CLK_PS   = 10000,
  parameter int DW       = 16,
  parameter int AW       = 4,
  parameter int CW       = 8,
  parameter int STAT_OFS = 7,
  parameter int ALT_OFS  = 14,
  parameter int WAIT_TOP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_set,
  input  logic [2:0]    mode_sel,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          cs_n,
  output logic          dior_n,
  output logic          diow_n,
  output logic [AW-1:0] da,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  input  logic [DW-1:0] dd_in,
  input  logic          iordy
);

  localparam int TOP_MODE = 6;
  localparam int NM       = TOP_MODE + 1;
  localparam int NPLAN    = 2 * NM;
  localparam int PW       = 5 * CW;

  function automatic int ns_tab(input int q, input int m);
    int t [7];
    case (q)
      0:       t = '{70, 50, 30, 30, 25, 15, 10};
      1:       t = '{290, 290, 290, 80, 70, 65, 55};
      2:       t = '{20, 15, 10, 10, 10, 10, 10};
      3:       t = '{30, 20, 15, 10, 10, 10, 10};
      4:       t = '{30, 30, 30, 30, 30, 20, 20};
      5:       t = '{0, 0, 0, 70, 25, 25, 20};
      default: t = '{600, 383, 240, 180, 120, 100, 80};
    endcase
    return t[m];
  endfunction

  function automatic int to_clk(input int ps);
    int slack;
    if (ps <= 0) return 0;
    slack = ps * 2 / 100;
    if (4 * slack > CLK_PS) slack = CLK_PS / 4;
    return (ps + CLK_PS - 1 - slack) / CLK_PS;
  endfunction

  function automatic logic [PW-1:0] phase_plan(input int m, input int wr);
    int c [5];
    int tot;
    int need;
    int k;
    logic [PW-1:0] p;
    c[0] = to_clk(ns_tab(0, m) * 1000);
    if (c[0] < 1) c[0] = 1;
    c[1] = to_clk(ns_tab(1, m) * 1000);
    if (c[1] < 2) c[1] = 2;
    c[2] = to_clk(ns_tab(2, m) * 1000);
    if (c[2] < 1) c[2] = 1;
    c[3] = to_clk(ns_tab(wr != 0 ? 3 : 4, m) * 1000 - c[2] * CLK_PS);
    c[4] = to_clk(ns_tab(5, m) * 1000);
    tot  = c[0] + c[1] + c[2] + c[3] + c[4];
    need = to_clk(ns_tab(6, m) * 1000);
    k = 0;
    while (tot < need) begin
      if (c[k] != 0) begin
        c[k] = c[k] + 1;
        tot  = tot + 1;
      end
      k = (k == 4) ? 0 : k + 1;
    end
    for (int i = 0; i < 5; i++) p[i*CW +: CW] = CW'(c[i]);
    return p;
  endfunction

  logic [PW-1:0] plan_tbl [NPLAN];

  for (genvar w = 0; w < 2; w++) begin : g_dir
    for (genvar m = 0; m < NM; m++) begin : g_mode
      localparam logic [PW-1:0] PLAN = phase_plan(m, w);
      assign plan_tbl[w*NM + m] = PLAN;
    end
  end

  typedef enum logic [2:0] {S_IDLE, S_SU, S_STB, S_HO, S_TAIL, S_RC} phase_t;

  phase_t        state;
  logic [CW-1:0] cnt;
  logic [2:0]    mode_q, cyc_mode;
  logic          mode_ok;
  logic          cyc_wr;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_wdata, rdata_q;
  logic          done_q;

  logic          idle, use_wr, stall, last, is_stat;
  logic [2:0]    use_mode, mode_clamped;
  logic [PW-1:0] pl;
  logic [CW-1:0] len_su, len_st, len_ho, len_tl, len_rc;
  logic [DW-1:0] rd_fixed;

  assign idle         = (state == S_IDLE);
  assign use_wr       = idle ? req_wr : cyc_wr;
  assign use_mode     = idle ? mode_q : cyc_mode;
  assign pl           = plan_tbl[(use_wr ? NM : 0) + int'(use_mode)];
  assign len_su       = pl[0*CW +: CW];
  assign len_st       = pl[1*CW +: CW];
  assign len_ho       = pl[2*CW +: CW];
  assign len_tl       = pl[3*CW +: CW];
  assign len_rc       = pl[4*CW +: CW];
  assign mode_clamped = (mode_sel > 3'(TOP_MODE)) ? 3'(TOP_MODE) : mode_sel;

  assign stall   = (state == S_STB) && (cnt == CW'(2)) && (cyc_mode <= 3'(WAIT_TOP)) && !iordy;
  assign last    = (cnt == CW'(1)) && !stall;
  assign is_stat = (cyc_addr == AW'(STAT_OFS)) || (cyc_addr == AW'(ALT_OFS));
  assign rd_fixed = (is_stat && dd_in[7:0] == 8'hF9) ? {dd_in[DW-1:8], 8'h7F} : dd_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 3'd0;
      mode_ok <= 1'b0;
    end else if (mode_set && (!mode_ok || mode_clamped < mode_q)) begin
      mode_q  <= mode_clamped;
      mode_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      cyc_mode  <= 3'd0;
      cyc_wr    <= 1'b0;
      cyc_addr  <= '0;
      cyc_wdata <= '0;
      rdata_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state == S_STB && cnt == CW'(2) && !stall && !cyc_wr) rdata_q <= rd_fixed;
      case (state)
        S_IDLE:
          if (req_valid) begin
            state     <= S_SU;
            cnt       <= len_su;
            cyc_mode  <= mode_q;
            cyc_wr    <= req_wr;
            cyc_addr  <= req_addr;
            cyc_wdata <= req_wdata;
          end
        S_SU:
          if (last) begin state <= S_STB; cnt <= len_st; end
          else cnt <= cnt - 1'b1;
        S_STB:
          if (last) begin state <= S_HO; cnt <= len_ho; end
          else if (!stall) cnt <= cnt - 1'b1;
        S_HO:
          if (last) begin
            if (len_tl != '0) begin state <= S_TAIL; cnt <= len_tl; end
            else if (len_rc != '0) begin state <= S_RC; cnt <= len_rc; end
            else begin state <= S_IDLE; done_q <= 1'b1; end
          end else cnt <= cnt - 1'b1;
        S_TAIL:
          if (last) begin
            if (len_rc != '0) begin state <= S_RC; cnt <= len_rc; end
            else begin state <= S_IDLE; done_q <= 1'b1; end
          end else cnt <= cnt - 1'b1;
        S_RC:
          if (last) begin state <= S_IDLE; done_q <= 1'b1; end
          else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = idle;
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign cs_n      = !(state == S_SU || state == S_STB || state == S_HO);
  assign dior_n    = !(state == S_STB && !cyc_wr);
  assign diow_n    = !(state == S_STB && cyc_wr);
  assign da        = cyc_addr;
  assign dd_out    = cyc_wdata;
  assign dd_oe     = cyc_wr && (state == S_SU || state == S_STB || state == S_HO || state == S_TAIL);

  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($fell(dior_n) || $fell(diow_n)) |-> $past(!cs_n)); // R5
  AST_HOLD_AFTER: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> $past(dior_n && diow_n)); // R5
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!diow_n && $past(!diow_n)) |-> $stable(dd_out)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> (state == S_STB && cnt == CW'(2))); // R8
  AST_FAST_NOWAIT: assert property (@(posedge clk) disable iff (rst)
    (state == S_STB && cnt == CW'(2) && cyc_mode > 3'(WAIT_TOP)) |=> (cnt == CW'(1))); // R8
  AST_MODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    mode_q <= 3'(TOP_MODE)); // R9
  AST_MODE_SLOWER: assert property (@(posedge clk) disable iff (rst)
    (mode_ok && $past(mode_ok)) |-> (mode_q <= $past(mode_q))); // R10
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (state == S_SU && !cs_n)); // R11

endmodule

// File: tb/pata_pio_engine_bench.sv
module pata_pio_engine_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        mode_set = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic        req_valid = 1'b0;
  logic        req_wr = 1'b0;
  logic [3:0]  req_addr = 4'd0;
  logic [15:0] req_wdata = 16'd0;
  logic [15:0] dd_in = 16'd0;
  logic        iordy = 1'b1;

  logic a_ready, a_done, a_cs_n, a_dior_n, a_diow_n, a_oe;
  logic b_ready, b_done, b_cs_n, b_dior_n, b_diow_n, b_oe;
  logic [15:0] a_rdata, a_dout, b_rdata, b_dout;
  logic [3:0]  a_da, b_da;

  pata_pio_engine u_pata_pio_engine (
    .clk(clk), .rst(rst), .mode_set(mode_set), .mode_sel(mode_sel),
    .req_valid(req_valid), .req_ready(a_ready), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(a_done), .rdata(a_rdata), .cs_n(a_cs_n),
    .dior_n(a_dior_n), .diow_n(a_diow_n), .da(a_da), .dd_out(a_dout), .dd_oe(a_oe),
    .dd_in(dd_in), .iordy(iordy));

  pata_pio_engine #(.CLK_PS(6000)) u_pata_pio_engine_b (
    .clk(clk), .rst(rst), .mode_set(mode_set), .mode_sel(mode_sel),
    .req_valid(req_valid), .req_ready(b_ready), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(b_done), .rdata(b_rdata), .cs_n(b_cs_n),
    .dior_n(b_dior_n), .diow_n(b_diow_n), .da(b_da), .dd_out(b_dout), .dd_oe(b_oe),
    .dd_in(dd_in), .iordy(iordy));

  logic which = 1'b0;
  logic m_ready, m_done, m_cs_n, m_dior_n, m_diow_n, m_oe;
  logic [15:0] m_rdata, m_dout;
  logic [3:0]  m_da;
  assign m_ready  = which ? b_ready  : a_ready;
  assign m_done   = which ? b_done   : a_done;
  assign m_cs_n   = which ? b_cs_n   : a_cs_n;
  assign m_dior_n = which ? b_dior_n : a_dior_n;
  assign m_diow_n = which ? b_diow_n : a_diow_n;
  assign m_oe     = which ? b_oe     : a_oe;
  assign m_rdata  = which ? b_rdata  : a_rdata;
  assign m_dout   = which ? b_dout   : a_dout;
  assign m_da     = which ? b_da     : a_da;

  int checks = 0;
  int errors = 0;
  int ms_su, ms_st, ms_ho, ms_post, ms_oe, ms_bad, ms_rdy;
  logic [15:0] ms_rd;

  // mode(3) wr(1) addr(4) setup strobe hold tail recovery (8 each), CLK_PS 10000
  localparam logic [47:0] VEC [14] = '{
    {3'd6, 1'b0, 4'h1, 8'd1,  8'd6,  8'd1, 8'd1, 8'd2},
    {3'd6, 1'b1, 4'h2, 8'd1,  8'd6,  8'd1, 8'd0, 8'd2},
    {3'd5, 1'b0, 4'h3, 8'd2,  8'd7,  8'd1, 8'd1, 8'd3},
    {3'd5, 1'b1, 4'h4, 8'd2,  8'd7,  8'd1, 8'd0, 8'd3},
    {3'd4, 1'b0, 4'h5, 8'd3,  8'd7,  8'd1, 8'd2, 8'd3},
    {3'd4, 1'b1, 4'h6, 8'd3,  8'd7,  8'd1, 8'd0, 8'd3},
    {3'd3, 1'b0, 4'h0, 8'd3,  8'd8,  8'd1, 8'd2, 8'd7},
    {3'd3, 1'b1, 4'h8, 8'd3,  8'd8,  8'd1, 8'd0, 8'd7},
    {3'd2, 1'b0, 4'h9, 8'd3,  8'd29, 8'd1, 8'd2, 8'd0},
    {3'd2, 1'b1, 4'hA, 8'd3,  8'd29, 8'd1, 8'd1, 8'd0},
    {3'd1, 1'b0, 4'hB, 8'd6,  8'd30, 8'd2, 8'd1, 8'd0},
    {3'd1, 1'b1, 4'hC, 8'd6,  8'd30, 8'd3, 8'd0, 8'd0},
    {3'd0, 1'b0, 4'hD, 8'd13, 8'd34, 8'd7, 8'd6, 8'd0},
    {3'd0, 1'b1, 4'hF, 8'd13, 8'd34, 8'd7, 8'd6, 8'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode_sel = m;
    mode_set = 1'b1;
    @(negedge clk);
    mode_set = 1'b0;
  endtask

  task automatic access(input logic [3:0] addr, input logic wr, input logic [15:0] wd,
                        input logic [15:0] din, input int exp_st, input int rel);
    logic seen;
    @(negedge clk);
    for (int g = 0; g < 400 && !(a_ready && b_ready); g++) @(negedge clk);
    req_addr = addr; req_wr = wr; req_wdata = wd; dd_in = din;
    ms_su = 0; ms_st = 0; ms_ho = 0; ms_post = 0; ms_oe = 0; ms_bad = 0; ms_rdy = 0;
    ms_rd = 16'hxxxx;
    seen = 1'b0;
    if (rel > 0) iordy = 1'b0;
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (m_done) begin
        ms_rd = m_rdata;
        break;
      end
      if (m_ready) ms_rdy++;
      if (m_da != addr) ms_bad++;
      if (!m_dior_n || !m_diow_n) begin
        if (m_cs_n) ms_bad++;
        if (wr ? !m_dior_n : !m_diow_n) ms_bad++;
        ms_st++;
        seen = 1'b1;
        if (!wr && ms_st == exp_st) dd_in = 16'hDEAD;
        if (rel > 0 && ms_st == rel) iordy = 1'b1;
      end else if (!m_cs_n) begin
        if (seen) ms_ho++; else ms_su++;
      end else begin
        ms_post++;
      end
      if (m_oe) begin
        ms_oe++;
        if (m_dout != wd) ms_bad++;
      end
    end
    iordy = 1'b1;
    dd_in = din;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] v;
    logic [15:0] din, wd;
    do_reset();
    @(negedge clk);
    chk("R1 ready after reset", a_ready, 1);
    chk("R1 bus idle after reset", {a_cs_n, a_dior_n, a_diow_n, a_oe, a_done}, 5'b11100);

    for (int i = 0; i < 14; i++) begin
      v = VEC[i];
      if (!v[44]) set_mode(v[47:45]);
      din = 16'h5A00 | 16'(v[43:40]);
      wd  = 16'hA5C0 ^ 16'(i);
      access(v[43:40], v[44], v[44] ? wd : 16'h0, v[44] ? 16'h0 : din, int'(v[31:24]), 0);
      chk($sformatf("R3 setup m%0d w%0d", v[47:45], v[44]), ms_su, int'(v[39:32]));
      chk($sformatf("R3 strobe m%0d w%0d", v[47:45], v[44]), ms_st, int'(v[31:24]));
      chk($sformatf("R4 hold m%0d w%0d", v[47:45], v[44]), ms_ho, int'(v[23:16]));
      chk($sformatf("R4 tail+recovery m%0d w%0d", v[47:45], v[44]), ms_post, int'(v[15:8]) + int'(v[7:0]));
      chk($sformatf("R5 framing m%0d w%0d", v[47:45], v[44]), ms_bad, 0);
      chk($sformatf("R11 ready low while busy m%0d", v[47:45]), ms_rdy, 0);
      if (v[44])
        chk($sformatf("R5 write drive cycles m%0d", v[47:45]), ms_oe,
            int'(v[39:32]) + int'(v[31:24]) + int'(v[23:16]) + int'(v[15:8]));
      else
        chk($sformatf("R6 read data m%0d", v[47:45]), int'(ms_rd), int'(din));
    end

    set_mode(3'd4);
    access(4'h3, 1'b0, 16'h0, 16'h1234, 34, 0);
    chk("R10 faster mode ignored", ms_st, 34);

    do_reset();
    @(negedge clk);
    chk("R1 idle after second reset", {a_ready, a_cs_n, a_oe}, 3'b110);
    access(4'h1, 1'b0, 16'h0, 16'h0042, 34, 0);
    chk("R1 default mode 0 setup", ms_su, 13);
    chk("R1 default mode 0 strobe", ms_st, 34);

    do_reset();
    set_mode(3'd7);
    access(4'h1, 1'b0, 16'h0, 16'h0043, 6, 0);
    chk("R9 mode 7 clamps to 6 strobe", ms_st, 6);
    chk("R9 mode 7 clamps to 6 setup", ms_su, 1);
    set_mode(3'd3);
    access(4'h1, 1'b0, 16'h0, 16'h0044, 8, 0);
    chk("R10 slower mode applied", ms_st, 8);
    set_mode(3'd5);
    access(4'h1, 1'b0, 16'h0, 16'h0045, 8, 0);
    chk("R10 faster mode after set ignored", ms_st, 8);

    access(4'h2, 1'b0, 16'h0, 16'h7E11, 21, 20);
    chk("R8 iordy stretches strobe", ms_st, 21);
    chk("R8 read data after wait", int'(ms_rd), 16'h7E11);

    access(4'h7, 1'b0, 16'h0, 16'h12F9, 8, 0);
    chk("R7 status fixup", int'(ms_rd), 16'h127F);
    access(4'hE, 1'b0, 16'h0, 16'h00F9, 8, 0);
    chk("R7 alt status fixup", int'(ms_rd), 16'h007F);
    access(4'h2, 1'b0, 16'h0, 16'h00F9, 8, 0);
    chk("R7 other address untouched", int'(ms_rd), 16'h00F9);
    access(4'h7, 1'b0, 16'h0, 16'h00F8, 8, 0);
    chk("R7 other value untouched", int'(ms_rd), 16'h00F8);

    do_reset();
    set_mode(3'd6);
    access(4'h4, 1'b0, 16'h0, 16'h3C3C, 6, 1000);
    chk("R8 iordy ignored in mode 6", ms_st, 6);
    chk("R8 read data mode 6", int'(ms_rd), 16'h3C3C);

    which = 1'b1;
    access(4'h4, 1'b0, 16'h0, 16'h1111, 9, 0);
    chk("R2 tolerance rounds strobe down", ms_st, 9);
    chk("R2 setup at 6 ns", ms_su, 2);
    chk("R2 hold at 6 ns", ms_ho, 2);
    chk("R3 tail+recovery at 6 ns", ms_post, 6);
    set_mode(3'd0);
    access(4'h5, 1'b0, 16'h0, 16'h2222, 58, 0);
    chk("R2 R4 capped strobe stretched", ms_st, 58);
    chk("R4 setup stretched", ms_su, 21);
    chk("R4 hold stretched", ms_ho, 12);
    chk("R4 tail stretched", ms_post, 9);
    chk("R6 read data slow copy", int'(ms_rd), 16'h2222);
    which = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule